// File: doc/BRIEF.md
# Long-Sync PCM Voice Port

This block moves 8-bit mu-law voice samples between a host and an external telephony codec over a four-wire serial link made of a bit clock, a frame sync, a data output and a data input. Each frame is 16 bit-clock periods long. The frame sync is a square wave with a 50% duty cycle: it is high for the first 8 bit periods of the frame and low for the last 8. During each frame the port sends one sample to the codec, most significant bit first, in the 8 bit periods that follow the sync rising edge. It holds the data line low for the rest of the frame. In the same bit periods it captures one sample from the codec. The port changes outgoing bits while the bit clock is high and samples incoming bits on its falling edge.

The port has two timing roles. In master mode it divides the system clock by a parameter to produce the bit clock and the frame sync, and drives both toward the codec. In slave mode the codec supplies both signals. The port passes them through a flip-flop synchronizer and detects their edges in the system clock domain. The host sees a one-entry transmit slot and a one-entry receive register, each with a valid/ready handshake, plus a role select and an enable level. After reset the port is idle, and it stays idle until the host raises the enable.

Top module: `pcmv_port`

## Requirements
- R1: While `en` is low (and after reset), `bclk_o`, `fsync_o` and `dout` stay low, `tx_ready` and `rx_valid` are 0, and any word offered on `tx_data` is dropped; dropping `en` clears all of this state one clock later.
- R2: In master mode the bit clock on `bclk_o` is high for exactly HALF_DIV system clocks and then low for HALF_DIV system clocks.
- R3: In master mode `fsync_o` rises on the same system clock edge as `bclk_o`, then stays high for 8 bit periods (16·HALF_DIV system clocks) and low for the next 8.
- R4: Starting with the bit period that opens with the sync rising edge, `dout` carries the transmitted sample, bit 7 first and bit 0 last, one bit per period. A new bit appears only when the bit clock rises. `dout` is 0 for bit periods 8 to 15 of the frame.
- R5: `din` is sampled on each falling bit-clock edge of bit periods 0 to 7, and the first bit sampled is placed in bit 7. After the eighth sample the byte appears on `rx_data` with `rx_valid` high, and `rx_valid` stays high until `rx_ready` is seen.
- R6: The transmit side holds one sample. `tx_ready` is high only while the port is enabled and the slot is empty. An accepted word is sent in the next frame that starts after it was accepted, and the slot is free again at that frame start.
- R7: If the transmit slot is empty when a frame starts, the frame carries the idle code 8'hFF.
- R8: If a new byte completes while `rx_valid` is still high and `rx_ready` is low, `rx_overrun` is set and the newer byte replaces the older one. `rx_overrun` stays set until `en` is dropped.
- R9: With `slave_mode` = 1 the port keeps `bclk_oe`, `fsync_oe`, `bclk_o` and `fsync_o` low. It takes its bit timing from `bclk_i`, starts a frame at the first `bclk_i` rise at or after a `fsync_i` rising edge, and transmits and receives as in R4 and R5.
- R10: With `slave_mode` = 0 and `en` = 1, `bclk_oe` and `fsync_oe` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable level from the host |
| slave_mode | input | 1 | 1: timing comes from the codec; 0: the port generates it |
| tx_data | input | SAMPLE_W | Sample to transmit |
| tx_valid | input | 1 | Host offers `tx_data` |
| tx_ready | output | 1 | Transmit slot empty and port enabled |
| rx_data | output | SAMPLE_W | Last received sample |
| rx_valid | output | 1 | `rx_data` holds an unread sample |
| rx_ready | input | 1 | Host takes `rx_data` |
| rx_overrun | output | 1 | Sticky: a received sample was overwritten |
| bclk_i | input | 1 | Bit clock from the codec (slave mode) |
| fsync_i | input | 1 | Frame sync from the codec (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| fsync_o | output | 1 | Generated frame sync (master mode) |
| bclk_oe | output | 1 | Drive enable for `bclk_o` |
| fsync_oe | output | 1 | Drive enable for `fsync_o` |
| dout | output | 1 | Serial data toward the codec |
| din | input | 1 | Serial data from the codec |

## Verification
In master mode, `dout` changes on the same system clock edge on which `bclk_o` rises. `rx_valid` rises on the edge where `bclk_o` falls for the eighth time in the frame, and `rx_ready` clears it on the next edge. In slave mode every result trails the codec edge that causes it by SYNC_STAGES + 1 system clocks, which is less than half a bit period. The bench therefore does not count cycles from a stimulus. Its codec model watches the link clock and compares at the bit-clock edges. It samples `dout` at the falling edge, half a bit period after the bit was launched, and pops the receive scoreboard whenever a handshake on `rx_valid`/`rx_ready` completes. Transmit words are offered only in bit periods 2 to 6, so the frame each word lands in is known without any cycle-exact race.

// File: rtl/pcmv_pkg.sv
package pcmv_pkg;

   // Bit-clock events seen in the system clock domain, one cycle wide.
   typedef struct packed {
      logic rise;    // bit clock goes high: launch the next bit
      logic fall;    // bit clock goes low: sample the incoming bit
      logic fstart;  // this rise opens a new frame
   } pcmv_evt_t;

endpackage

// File: rtl/pcmv_master_tmg.sv
module pcmv_master_tmg
   import pcmv_pkg::*;
#(
   parameter int HALF_DIV   = 4,
   parameter int FRAME_BITS = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run,
   output logic      bclk,
   output logic      fsync,
   output pcmv_evt_t evt
);

   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam int BW = $clog2(FRAME_BITS);
   localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);
   localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);
   localparam logic [BW-1:0] SYNC_END = BW'(FRAME_BITS / 2);

   logic [CW-1:0] cnt;
   logic [BW-1:0] bidx;
   logic [BW-1:0] bidx_nxt;
   logic          tick;

   assign tick     = run && (cnt == CNT_LAST);
   assign bidx_nxt = (bidx == BIT_LAST) ? '0 : bidx + 1'b1;

   assign evt.rise   = tick && !bclk;
   assign evt.fall   = tick && bclk;
   assign evt.fstart = tick && !bclk && (bidx_nxt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         bclk  <= 1'b0;
         fsync <= 1'b0;
         bidx  <= BIT_LAST;
      end else if (!run) begin
         cnt   <= '0;
         bclk  <= 1'b0;
         fsync <= 1'b0;
         bidx  <= BIT_LAST;
      end else if (tick) begin
         cnt  <= '0;
         bclk <= !bclk;
         if (!bclk) begin
            bidx  <= bidx_nxt;
            fsync <= (bidx_nxt < SYNC_END);
         end
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/pcmv_slave_tmg.sv
module pcmv_slave_tmg
   import pcmv_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run,
   input  logic      bclk_in,
   input  logic      fsync_in,
   input  logic      din_in,
   output logic      din_s,
   output pcmv_evt_t evt
);

   logic [2:0] raw;
   logic [2:0] synced;
   logic       prev_bclk;
   logic       prev_sync;
   logic       pend;
   logic       srise;

   assign raw = {din_in, fsync_in, bclk_in};

   for (genvar g = 0; g < 3; g++) begin : g_sync
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[STAGES-1];
   end

   assign din_s      = synced[2];
   assign srise      = synced[1] && !prev_sync;
   assign evt.rise   = run && synced[0] && !prev_bclk;
   assign evt.fall   = run && !synced[0] && prev_bclk;
   assign evt.fstart = run && synced[0] && !prev_bclk && (pend || srise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_bclk <= 1'b0;
         prev_sync <= 1'b0;
         pend      <= 1'b0;
      end else begin
         prev_bclk <= synced[0];
         prev_sync <= synced[1];
         if (!run || evt.rise) pend <= 1'b0;
         else if (srise)       pend <= 1'b1;
      end
   end

endmodule

// File: rtl/pcmv_engine.sv
module pcmv_engine
   import pcmv_pkg::*;
#(
   parameter int SAMPLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  pcmv_evt_t           evt,
   input  logic                din,
   input  logic [SAMPLE_W-1:0] tx_data,
   input  logic                tx_valid,
   output logic                tx_ready,
   output logic                dout,
   output logic [SAMPLE_W-1:0] rx_data,
   output logic                rx_valid,
   input  logic                rx_ready,
   output logic                rx_overrun
);

   localparam int CW = $clog2(SAMPLE_W + 1);
   localparam logic [CW-1:0] NBITS = CW'(SAMPLE_W);
   localparam logic [CW-1:0] LASTB = CW'(SAMPLE_W - 1);
   localparam logic [SAMPLE_W-1:0] IDLE_CODE = '1;

   logic [SAMPLE_W-1:0] tx_hold;
   logic                tx_full;
   logic [SAMPLE_W-1:0] tx_sh;
   logic [CW-1:0]       tcnt;
   logic [SAMPLE_W-1:0] rx_sh;
   logic [CW-1:0]       rcnt;
   logic [SAMPLE_W-1:0] first_word;
   logic [SAMPLE_W-1:0] rx_word;

   assign tx_ready   = run && !tx_full;
   assign first_word = tx_full ? tx_hold : IDLE_CODE;
   assign rx_word    = {rx_sh[SAMPLE_W-2:0], din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_hold    <= '0;
         tx_full    <= 1'b0;
         tx_sh      <= '0;
         tcnt       <= NBITS;
         dout       <= 1'b0;
         rx_sh      <= '0;
         rcnt       <= NBITS;
         rx_data    <= '0;
         rx_valid   <= 1'b0;
         rx_overrun <= 1'b0;
      end else if (!run) begin
         tx_full    <= 1'b0;
         tcnt       <= NBITS;
         dout       <= 1'b0;
         rcnt       <= NBITS;
         rx_valid   <= 1'b0;
         rx_overrun <= 1'b0;
      end else begin
         // transmit: frame start takes the slot (or the idle code)
         if (evt.fstart) begin
            dout    <= first_word[SAMPLE_W-1];
            tx_sh   <= first_word << 1;
            tcnt    <= CW'(1);
            tx_full <= 1'b0;
         end else if (evt.rise) begin
            if (tcnt < NBITS) begin
               dout  <= tx_sh[SAMPLE_W-1];
               tx_sh <= tx_sh << 1;
               tcnt  <= tcnt + 1'b1;
            end else begin
               dout <= 1'b0;
            end
         end
         if (tx_valid && tx_ready) begin
            tx_hold <= tx_data;
            tx_full <= 1'b1;
         end
         // receive
         if (rx_valid && rx_ready) rx_valid <= 1'b0;
         if (evt.fstart) begin
            rcnt <= '0;
         end else if (evt.fall && (rcnt < NBITS)) begin
            rx_sh <= rx_word;
            rcnt  <= rcnt + 1'b1;
            if (rcnt == LASTB) begin
               rx_data  <= rx_word;
               rx_valid <= 1'b1;
               if (rx_valid && !rx_ready) rx_overrun <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pcmv_port.sv
module pcmv_port
   import pcmv_pkg::*;
#(
   parameter int SAMPLE_W    = 8,
   parameter int FRAME_BITS  = 16,
   parameter int HALF_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                slave_mode,
   input  logic [SAMPLE_W-1:0] tx_data,
   input  logic                tx_valid,
   output logic                tx_ready,
   output logic [SAMPLE_W-1:0] rx_data,
   output logic                rx_valid,
   input  logic                rx_ready,
   output logic                rx_overrun,
   input  logic                bclk_i,
   input  logic                fsync_i,
   output logic                bclk_o,
   output logic                fsync_o,
   output logic                bclk_oe,
   output logic                fsync_oe,
   output logic                dout,
   input  logic                din
);

   if (SAMPLE_W < 2) begin : g_chk_w
      $error("pcmv_port: SAMPLE_W must be at least 2");
   end
   if ((FRAME_BITS < 2 * SAMPLE_W) || (FRAME_BITS % 2 != 0) ||
       ((FRAME_BITS & (FRAME_BITS - 1)) != 0)) begin : g_chk_f
      $error("pcmv_port: FRAME_BITS must be an even power of two >= 2*SAMPLE_W");
   end
   if (HALF_DIV < 2) begin : g_chk_d
      $error("pcmv_port: HALF_DIV must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_chk_s
      $error("pcmv_port: SYNC_STAGES must be at least 2");
   end

   logic      run_m;
   logic      run_s;
   pcmv_evt_t evt_m;
   pcmv_evt_t evt_s;
   pcmv_evt_t evt;
   logic      din_s;
   logic      din_sel;

   assign run_m = en && !slave_mode;
   assign run_s = en && slave_mode;

   pcmv_master_tmg #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_mtmg (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_m),
      .bclk  (bclk_o),
      .fsync (fsync_o),
      .evt   (evt_m)
   );

   pcmv_slave_tmg #(.STAGES(SYNC_STAGES)) u_stmg (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_s),
      .bclk_in  (bclk_i),
      .fsync_in (fsync_i),
      .din_in   (din),
      .din_s    (din_s),
      .evt      (evt_s)
   );

   assign evt      = slave_mode ? evt_s : evt_m;
   assign din_sel  = slave_mode ? din_s : din;
   assign bclk_oe  = run_m;
   assign fsync_oe = run_m;

   pcmv_engine #(.SAMPLE_W(SAMPLE_W)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (en),
      .evt        (evt),
      .din        (din_sel),
      .tx_data    (tx_data),
      .tx_valid   (tx_valid),
      .tx_ready   (tx_ready),
      .dout       (dout),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .rx_ready   (rx_ready),
      .rx_overrun (rx_overrun)
   );

endmodule

// File: rtl/pcmv_port_chk.sv
module pcmv_port_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic slave_mode,
   input logic tx_valid,
   input logic tx_ready,
   input logic rx_valid,
   input logic rx_ready,
   input logic rx_overrun,
   input logic bclk_o,
   input logic fsync_o,
   input logic bclk_oe,
   input logic fsync_oe,
   input logic dout
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!dout && !bclk_o && !fsync_o && !rx_valid)); // R1

   AST_SYNC_ON_CLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync_o) |-> $rose(bclk_o)); // R3

   AST_DOUT_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !slave_mode && !$past(slave_mode) && !$rose(bclk_o))
         |-> $stable(dout)); // R4

   AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready && en) |=> rx_valid); // R5

   AST_TX_SLOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready); // R6

   AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_overrun && en) |=> rx_overrun); // R8

   AST_SLAVE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_mode && $past(slave_mode)) |-> (!bclk_oe && !fsync_oe && !bclk_o && !fsync_o)); // R9

endmodule

bind pcmv_port pcmv_port_chk chk_i (.*);

// File: tb/pcmv_port_tb_top.sv
module pcmv_port_tb_top;

   localparam int H  = 4;   // master half bit period in system clocks
   localparam int SH = 6;   // slave half bit period generated by the bench

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       slave_mode = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       rx_ready = 1'b0;
   logic       rx_overrun;
   logic       bclk_i = 1'b0;
   logic       fsync_i = 1'b0;
   logic       bclk_o, fsync_o, bclk_oe, fsync_oe, dout;
   logic       din = 1'b0;

   always #10 clk = ~clk;

   pcmv_port #(.HALF_DIV(H)) dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .slave_mode(slave_mode),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .rx_overrun(rx_overrun), .bclk_i(bclk_i), .fsync_i(fsync_i),
      .bclk_o(bclk_o), .fsync_o(fsync_o), .bclk_oe(bclk_oe),
      .fsync_oe(fsync_oe), .dout(dout), .din(din)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] tx_exp[$];
   logic [7:0] rx_exp[$];

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- codec model, slave clock generator and monitor -------
   bit         codec_on = 1'b0;
   bit         sgen_on  = 1'b0;
   bit         mon_off  = 1'b0;
   int         bitpos   = 99;
   int         scnt = 0;
   int         sbit = 15;
   logic       pb = 1'b0, ps = 1'b0, sync_at_rise = 1'b0;
   logic       cb, cs;
   logic [7:0] cap = '0, txe = '0, rxb = '0, rx_seed = 8'h96;
   logic       hi_seen = 1'b0;
   int         bh_len = 0, sh_len = 0;
   int         rx_seen = 0;

   always @(negedge clk) begin
      if (sgen_on) begin
         scnt++;
         if (scnt == SH) begin
            scnt = 0;
            bclk_i = ~bclk_i;
            if (bclk_i) begin
               sbit = (sbit + 1) % 16;
               fsync_i = (sbit < 8);
            end
         end
      end
      cb = slave_mode ? bclk_i : bclk_o;
      cs = slave_mode ? fsync_i : fsync_o;
      if (!codec_on) begin
         bitpos = 99;
         sync_at_rise = 1'b0;
         din = 1'b0;
         bh_len = 0;
         sh_len = 0;
      end else begin
         if (cb && !pb) begin
            if (cs && !sync_at_rise) begin
               bitpos = 0;
               txe = (tx_exp.size() > 0) ? tx_exp.pop_front() : 8'hFF;
               rxb = rx_seed;
               rx_seed = rx_seed + 8'h3B;
               rx_exp.push_back(rxb);
               hi_seen = 1'b0;
            end else if (bitpos < 99) begin
               bitpos++;
            end
            sync_at_rise = cs;
            din = (bitpos < 8) ? rxb[7 - bitpos] : 1'b0;
         end
         if (!cb && pb && bitpos < 16) begin
            if (bitpos < 8) begin
               cap = {cap[6:0], dout};
               if (bitpos == 7)
                  chk(cap == txe, (txe == 8'hFF) ? "R7 idle code" :
                      (slave_mode ? "R9 slave transmit" : "R4 transmit byte"), cap, txe);
            end else begin
               hi_seen = hi_seen | dout;
               if (bitpos == 15) chk(!hi_seen, "R4 dout low in second half", hi_seen, 0);
            end
         end
         if (!slave_mode) begin
            if (cs && !ps) chk(cb && !pb, "R3 sync rises with bit clock", cb, 1);
            if (cb) bh_len++;
            else if (pb) begin
               chk(bh_len == H, "R2 bit clock high time", bh_len, H);
               bh_len = 0;
            end
            if (cs) sh_len++;
            else if (ps) begin
               chk(sh_len == 16 * H, "R3 sync high time", sh_len, 16 * H);
               sh_len = 0;
            end
         end
      end
      pb = cb;
      ps = cs;
      // receive scoreboard
      if (!mon_off && rx_valid && rx_ready) begin
         rx_seen++;
         if (rx_exp.size() == 0) chk(1'b0, "R5 unexpected receive", rx_data, 0);
         else begin
            logic [7:0] e;
            e = rx_exp.pop_front();
            chk(rx_data == e, slave_mode ? "R9 slave receive" : "R5 receive byte", rx_data, e);
         end
      end
   end

   // ---------------- driver ----------------
   task automatic send(input logic [7:0] b);
      @(negedge clk);
      while (!(tx_ready && bitpos >= 2 && bitpos <= 6)) @(negedge clk);
      tx_data  = b;
      tx_valid = 1'b1;
      tx_exp.push_back(b);
      @(negedge clk);
      tx_valid = 1'b0;
      chk(!tx_ready, "R6 slot full after accept", tx_ready, 0);
   endtask

   task automatic wait_bit(input int b);
      @(negedge clk);
      while (bitpos == b) @(negedge clk);
      while (bitpos != b) @(negedge clk);
   endtask

   task automatic wait_frames(input int n);
      for (int i = 0; i < n; i++) wait_bit(0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      int highs;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!bclk_o && !fsync_o && !dout, "R1 reset outputs low", {bclk_o, fsync_o, dout}, 0);
      chk(!tx_ready && !rx_valid && !rx_overrun, "R1 reset handshake idle",
          {tx_ready, rx_valid, rx_overrun}, 0);
      // R1 offer while disabled is dropped
      tx_data = 8'h11; tx_valid = 1'b1;
      highs = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (bclk_o || fsync_o || dout || tx_ready) highs++;
      end
      tx_valid = 1'b0;
      chk(highs == 0, "R1 disabled port stays quiet", highs, 0);

      // ---- master mode ----
      en = 1'b1; rx_ready = 1'b1; codec_on = 1'b1;
      @(negedge clk);
      chk(bclk_oe && fsync_oe, "R10 master drive enables", {bclk_oe, fsync_oe}, 2'b11);
      chk(tx_ready, "R6 slot free after enable", tx_ready, 1);
      send(8'hA5);
      send(8'h3C);
      send(8'h01);
      send(8'h80);
      wait_frames(3);
      chk(tx_exp.size() == 0, "R6 all words sent", tx_exp.size(), 0);
      chk(rx_seen >= 5, "R5 receive bytes delivered", rx_seen, 5);

      // ---- overrun ----
      wait_bit(9);
      rx_ready = 1'b0;
      wait_bit(9);
      wait_bit(9);
      chk(rx_valid && rx_overrun, "R8 overrun flagged", {rx_valid, rx_overrun}, 2'b11);
      chk(rx_data == rxb, "R8 newer byte kept", rx_data, rxb);
      mon_off = 1'b1;
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
      @(negedge clk);
      chk(!rx_valid && rx_overrun, "R8 overrun sticky after read", {rx_valid, rx_overrun}, 2'b01);
      en = 1'b0; codec_on = 1'b0;
      repeat (2) @(negedge clk);
      chk(!rx_overrun && !bclk_o && !fsync_o && !dout, "R1 disable clears state",
          {rx_overrun, bclk_o, fsync_o, dout}, 0);
      tx_exp.delete();
      rx_exp.delete();

      // ---- slave mode ----
      slave_mode = 1'b1;
      @(negedge clk);
      mon_off = 1'b0; rx_ready = 1'b1; rx_seen = 0;
      en = 1'b1; codec_on = 1'b1; sgen_on = 1'b1;
      @(negedge clk);
      chk(!bclk_oe && !fsync_oe, "R9 slave does not drive", {bclk_oe, fsync_oe}, 0);
      send(8'h5A);
      send(8'hC3);
      wait_frames(3);
      highs = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (bclk_o || fsync_o) highs++;
      end
      chk(highs == 0, "R9 master outputs low in slave mode", highs, 0);
      chk(rx_seen >= 4, "R9 slave receive delivered", rx_seen, 4);
      chk(tx_exp.size() == 0, "R9 slave words sent", tx_exp.size(), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule